// File: doc/BRIEF.md
# Synchronous Burst Bus Master Sequencer

This block turns read requests from an internal requester into transfers on a synchronous bus with 32-bit addresses and 32-bit data. A request asks for either one long word or a full 16-byte line of four long words. For each transfer the block pulses a start strobe for one clock. It holds a busy level for the whole transfer. It drives the word-aligned address, a two-bit access kind and the index of the long word in the current beat. It then waits for the slave to answer each beat with a normal acknowledge, an error acknowledge, or both together.

A line fill begins at the long word the requester addressed and wraps modulo four inside the line. Each successful beat sends one long word back to the requester, tagged with its index. If both acknowledges arrive together on the first beat of a line fill, the block reruns the transfer from that beat with a fresh start strobe. The same pair on any later beat, or on a single transfer, ends the transfer with an error. When the transfer finishes, the requester sees a one-clock done pulse with an error flag.

The request side is a valid/ready handshake. Ready is high exactly while the bus is idle, and a request is taken on a rising edge where both valid and ready are high. The returned data is a valid-only stream without back-pressure: the requester must accept every beat in the cycle it is offered. The bus cannot be stalled mid-burst.

Top module: `burst_bus_master`

## Requirements
- R1: While reset is high and right after it, start strobe, busy level, done and data valid are low and request ready is high.
- R2: A request is accepted only on a rising edge where req_valid and req_ready are both high. req_ready is high exactly when the busy level is low.
- R3: The start strobe is high for exactly one clock, in the cycle after a request is accepted and in the cycle after a rerun is decided, and at no other time.
- R4: The busy level rises together with the start strobe. It stays high until the edge that ends the transfer, and it falls in the same cycle that done pulses.
- R5: While busy, bus_addr equals the requested address with its two low bits cleared. bus_kind is 2'b01 for a line fill and 2'b00 for a single transfer, and neither changes during the transfer.
- R6: bus_ln starts at request address bits [3:2] and, after each normal-only acknowledge inside a line fill, steps by one modulo four.
- R7: A normal-only acknowledge sampled while busy produces rsp_valid in the next cycle, with the sampled bus data and the bus_ln value of that beat.
- R8: A single transfer ends after one normal acknowledge, and a line fill ends after four. In both cases done pulses with done_err low.
- R9: An error-only acknowledge ends the transfer at once: done pulses with done_err high, no data is returned, and remaining beats are dropped.
- R10: Both acknowledges on the first beat of a line fill cause a rerun: no done, no data, the start strobe repeats in the next cycle, and bus_ln and the beat position are unchanged.
- R11: Both acknowledges on a later beat of a line fill, or on a single transfer, end the transfer with done_err high and no data for that beat.
- R12: Acknowledges while the busy level is low have no effect: no data, no done, and no change to the bus outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything acts on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Requester offers a transfer |
| req_ready | output | 1 | Sequencer can take a transfer (bus idle) |
| req_addr | input | 32 | Byte address of the requested long word |
| req_line | input | 1 | 1: four-beat line fill, 0: single long word |
| bus_addr | output | 32 | Word-aligned address on the bus |
| bus_kind | output | 2 | Access kind: 00 single, 01 line fill |
| bus_ts | output | 1 | One-clock transfer start strobe |
| bus_tip | output | 1 | Transfer-in-progress level |
| bus_ln | output | 2 | Long-word index of the current beat |
| bus_ta | input | 1 | Slave normal acknowledge |
| bus_tea | input | 1 | Slave error acknowledge |
| bus_rdata | input | 32 | Read data from the slave |
| rsp_valid | output | 1 | Returned long word is valid (no back-pressure) |
| rsp_data | output | 32 | Returned long word |
| rsp_idx | output | 2 | Index of the returned long word |
| done | output | 1 | One-clock pulse at the end of a transfer |
| done_err | output | 1 | Error flag, meaningful while done is high |

## Verification
The start strobe, busy level, address, kind and index appear one cycle after the edge that accepts a request. Each returned long word appears one cycle after the edge that sampled its acknowledge. Done and the falling busy level appear one cycle after the ending acknowledge. A rerun shows as a second strobe one cycle after the acknowledging edge. The bench runs a behavioural model that updates on the same rising edge as the design and compares every output on the following falling edge, so each result is checked in exactly the cycle it is due. Slave acknowledge scripts cover wait states, wrapping start indices, errors on each beat, repeated reruns and noise while idle.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
  typedef enum logic [1:0] {
    KIND_SINGLE = 2'b00,
    KIND_LINE   = 2'b01
  } xfer_kind_e;

  typedef enum logic {
    SEQ_IDLE,
    SEQ_BUSY
  } seq_state_e;
endpackage

// File: rtl/bbm_req_latch.sv
module bbm_req_latch
  import bbm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [AW-1:0]            in_addr,
  input  logic                     in_line,
  output logic [AW-1:0]            out_addr,
  output xfer_kind_e               out_kind,
  output logic [$clog2(BEATS)-1:0] start_idx
);
  localparam int LSB = $clog2(DW / 8);
  localparam int IW  = $clog2(BEATS);
  localparam logic [AW-1:0] ALIGN_MASK = ~AW'((1 << LSB) - 1);

  assign start_idx = in_addr[LSB +: IW];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_addr <= '0;
      out_kind <= KIND_SINGLE;
    end else if (load) begin
      out_addr <= in_addr & ALIGN_MASK;
      out_kind <= in_line ? KIND_LINE : KIND_SINGLE;
    end
  end

  assert_addr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(out_addr) && $stable(out_kind));
endmodule

// File: rtl/bbm_beat_ctr.sv
module bbm_beat_ctr #(
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [$clog2(BEATS)-1:0] start_idx,
  input  logic                     advance,
  output logic [$clog2(BEATS)-1:0] idx,
  output logic                     first_beat,
  output logic                     last_beat
);
  localparam int IW = $clog2(BEATS);
  localparam logic [IW-1:0] LAST = IW'(BEATS - 1);

  logic [IW-1:0] beat;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat <= '0;
      idx  <= '0;
    end else if (load) begin
      beat <= '0;
      idx  <= start_idx;
    end else if (advance) begin
      beat <= beat + 1'b1;
      idx  <= idx + 1'b1;
    end
  end

  assign first_beat = (beat == '0);
  assign last_beat  = (beat == LAST);

  assert_idx_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    advance && !load |=> idx == IW'($past(idx) + 1'b1));
  assert_load_idx_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> idx == $past(start_idx) && first_beat);
endmodule

// File: rtl/bbm_seq.sv
module bbm_seq
  import bbm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic line,
  input  logic first_beat,
  input  logic last_beat,
  input  logic bus_ta,
  input  logic bus_tea,
  output logic req_ready,
  output logic load,
  output logic capture,
  output logic advance,
  output logic bus_ts,
  output logic bus_tip,
  output logic done,
  output logic done_err
);
  seq_state_e state;
  logic retry, fail, finish_ok;

  assign bus_tip   = (state == SEQ_BUSY);
  assign req_ready = (state == SEQ_IDLE);

  always_comb begin
    load      = req_valid && (state == SEQ_IDLE);
    capture   = bus_tip && bus_ta && !bus_tea;
    retry     = bus_tip && bus_ta && bus_tea && line && first_beat;
    fail      = bus_tip && bus_tea && !retry;
    finish_ok = capture && (!line || last_beat);
    advance   = capture && line && !last_beat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_IDLE;
      bus_ts   <= 1'b0;
      done     <= 1'b0;
      done_err <= 1'b0;
    end else begin
      bus_ts   <= load || retry;
      done     <= finish_ok || fail;
      done_err <= fail;
      case (state)
        SEQ_IDLE: if (load) state <= SEQ_BUSY;
        SEQ_BUSY: if (finish_ok || fail) state <= SEQ_IDLE;
        default:  state <= SEQ_IDLE;
      endcase
    end
  end

  assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> bus_ts && bus_tip);
  assert_ts_once_R3: assert property (@(posedge clk) disable iff (rst)
    bus_ts |=> !bus_ts || $past(bus_ta && bus_tea));
  assert_ts_in_tip_R4: assert property (@(posedge clk) disable iff (rst)
    bus_ts |-> bus_tip);
  assert_end_done_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_tip) |-> done);
  assert_err_abort_R9: assert property (@(posedge clk) disable iff (rst)
    bus_tip && bus_tea && !bus_ta |=> done && done_err && !bus_tip);
  assert_rerun_R10: assert property (@(posedge clk) disable iff (rst)
    bus_tip && bus_ta && bus_tea && line && first_beat |=> bus_ts && bus_tip && !done);
  assert_idle_ack_R12: assert property (@(posedge clk) disable iff (rst)
    !bus_tip && !req_valid |=> !done && !bus_tip);
endmodule

// File: rtl/bbm_rdata.sv
module bbm_rdata #(
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] din,
  input  logic [IW-1:0] din_idx,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic [IW-1:0] rsp_idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_idx   <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) begin
        rsp_data <= din;
        rsp_idx  <= din_idx;
      end
    end
  end

  assert_beat_data_R7: assert property (@(posedge clk) disable iff (rst)
    capture |=> rsp_valid && rsp_data == $past(din) && rsp_idx == $past(din_idx));
endmodule

// File: rtl/burst_bus_master.sv
module burst_bus_master
  import bbm_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [AW-1:0]            req_addr,
  input  logic                     req_line,
  output logic [AW-1:0]            bus_addr,
  output logic [1:0]               bus_kind,
  output logic                     bus_ts,
  output logic                     bus_tip,
  output logic [$clog2(BEATS)-1:0] bus_ln,
  input  logic                     bus_ta,
  input  logic                     bus_tea,
  input  logic [DW-1:0]            bus_rdata,
  output logic                     rsp_valid,
  output logic [DW-1:0]            rsp_data,
  output logic [$clog2(BEATS)-1:0] rsp_idx,
  output logic                     done,
  output logic                     done_err
);
  localparam int IW = $clog2(BEATS);

  logic          load, capture, advance, first_beat, last_beat;
  logic [IW-1:0] start_idx;
  xfer_kind_e    kind;

  bbm_req_latch #(.AW(AW), .DW(DW), .BEATS(BEATS)) u_latch (
    .clk(clk), .rst(rst), .load(load), .in_addr(req_addr), .in_line(req_line),
    .out_addr(bus_addr), .out_kind(kind), .start_idx(start_idx)
  );

  bbm_beat_ctr #(.BEATS(BEATS)) u_beats (
    .clk(clk), .rst(rst), .load(load), .start_idx(start_idx), .advance(advance),
    .idx(bus_ln), .first_beat(first_beat), .last_beat(last_beat)
  );

  bbm_seq u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .line(kind == KIND_LINE),
    .first_beat(first_beat), .last_beat(last_beat), .bus_ta(bus_ta), .bus_tea(bus_tea),
    .req_ready(req_ready), .load(load), .capture(capture), .advance(advance),
    .bus_ts(bus_ts), .bus_tip(bus_tip), .done(done), .done_err(done_err)
  );

  bbm_rdata #(.DW(DW), .IW(IW)) u_rdata (
    .clk(clk), .rst(rst), .capture(capture), .din(bus_rdata), .din_idx(bus_ln),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_idx(rsp_idx)
  );

  assign bus_kind = kind;
endmodule

// File: tb/test_burst_bus_master.sv
module test_burst_bus_master;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [31:0] req_addr  = '0;
  logic        req_line  = 1'b0;
  logic        bus_ta    = 1'b0;
  logic        bus_tea   = 1'b0;
  logic [31:0] bus_rdata = '0;
  logic        req_ready, bus_ts, bus_tip, rsp_valid, done, done_err;
  logic [31:0] bus_addr, rsp_data;
  logic [1:0]  bus_kind, bus_ln, rsp_idx;

  burst_bus_master i_burst_bus_master (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_line(req_line), .bus_addr(bus_addr), .bus_kind(bus_kind),
    .bus_ts(bus_ts), .bus_tip(bus_tip), .bus_ln(bus_ln), .bus_ta(bus_ta),
    .bus_tea(bus_tea), .bus_rdata(bus_rdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_idx(rsp_idx), .done(done), .done_err(done_err)
  );

  int total = 0;
  int bad   = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  bit idle_noise = 1'b0;
  int ackq[$];
  int cyc = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_busy, m_ts, m_line, m_done, m_err, m_rv, m_idle_ack;
  logic [31:0] m_addr, m_rd;
  int          m_beat, m_ln, m_ri;
  string       m_ttag = "R3";
  string       m_dtag = "R8";

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_ts = 0; m_done = 0; m_err = 0; m_rv = 0; m_idle_ack = 0;
      m_ln = 0; m_beat = 0;
    end else begin
      m_done = 0; m_rv = 0; m_ttag = "R3";
      if (!m_busy) begin
        m_idle_ack = bus_ta || bus_tea;
        if (req_valid) begin
          m_busy = 1; m_ts = 1; m_line = req_line;
          m_addr = {req_addr[31:2], 2'b00};
          m_beat = 0; m_ln = int'(req_addr[3:2]);
        end else m_ts = 0;
      end else begin
        m_idle_ack = 0;
        m_ts = 0;
        if (bus_ta && bus_tea) begin
          if (m_line && m_beat == 0) begin
            m_ts = 1; m_ttag = "R10";
          end else begin
            m_busy = 0; m_done = 1; m_err = 1; m_dtag = "R11";
          end
        end else if (bus_tea) begin
          m_busy = 0; m_done = 1; m_err = 1; m_dtag = "R9";
        end else if (bus_ta) begin
          m_rv = 1; m_rd = bus_rdata; m_ri = m_ln;
          if (!m_line || m_beat == 3) begin
            m_busy = 0; m_done = 1; m_err = 0; m_dtag = "R8";
          end else begin
            m_beat++; m_ln = (m_ln + 1) % 4;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (running && !rst && !finished) begin
      chk(bus_ts == m_ts, m_ttag, bus_ts, m_ts);
      chk(bus_tip == m_busy, "R4", bus_tip, m_busy);
      chk(req_ready == !m_busy, "R2", req_ready, !m_busy);
      if (m_busy) begin
        chk(bus_addr == m_addr, "R5", bus_addr, m_addr);
        chk(bus_kind == (m_line ? 2'b01 : 2'b00), "R5", bus_kind, m_line);
        chk(int'(bus_ln) == m_ln, "R6", bus_ln, m_ln);
      end
      chk(rsp_valid == m_rv, m_idle_ack ? "R12" : "R7", rsp_valid, m_rv);
      if (m_rv) begin
        chk(rsp_data == m_rd, "R7", rsp_data, m_rd);
        chk(int'(rsp_idx) == m_ri, "R6", rsp_idx, m_ri);
      end
      chk(done == m_done, m_idle_ack ? "R12" : "R8", done, m_done);
      if (m_done) chk(done_err == m_err, m_dtag, done_err, m_err);
    end
  end

  // scripted slave: 0 wait, 1 normal, 2 error, 3 both
  always @(negedge clk) begin
    int code;
    #1;
    if (bus_tip) code = (ackq.size() > 0) ? ackq.pop_front() : 1;
    else code = idle_noise ? int'($urandom % 4) : 0;
    bus_ta    = code[0];
    bus_tea   = code[1];
    bus_rdata = $urandom;
  end

  task automatic run(input logic [31:0] a, input bit line);
    @(negedge clk); #2;
    while (!req_ready) begin @(negedge clk); #2; end
    req_valid = 1'b1; req_addr = a; req_line = line;
    @(negedge clk); #2;
    req_valid = 1'b0;
    while (bus_tip) begin @(negedge clk); #2; end
    ackq.delete();
  endtask

  task automatic summary;
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !finished) begin
      total++; bad++;
      $display("FAIL R4 watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(bus_ts == 0, "R1", bus_ts, 0);
    chk(bus_tip == 0, "R1", bus_tip, 0);
    chk(done == 0, "R1", done, 0);
    chk(rsp_valid == 0, "R1", rsp_valid, 0);
    chk(req_ready == 1, "R1", req_ready, 1);
    rst = 1'b0;
    running = 1'b1;

    ackq = '{1};             run(32'h1000_0004, 0); // single, zero wait (R8)
    ackq = '{0, 0, 1};       run(32'h2000_0013, 0); // single, waits, misaligned (R5)
    ackq = '{1, 0, 1, 1, 0, 1}; run(32'h3000_0028, 1); // burst from index 2 (R6)
    ackq = '{1, 1, 2};       run(32'h4000_0000, 1); // error on beat 3 (R9)
    ackq = '{3, 0, 1, 1, 1, 1}; run(32'h5000_003C, 1); // rerun on first beat (R10)
    ackq = '{1, 3};          run(32'h6000_0044, 1); // both on beat 2 (R11)
    ackq = '{3};             run(32'h7000_0008, 0); // both on single (R11)
    ackq = '{2};             run(32'h8000_0010, 1); // error on first beat (R9)
    idle_noise = 1'b1;                             // acks while idle (R12)
    repeat (12) @(negedge clk);
    #3 idle_noise = 1'b0;
    ackq = '{1, 1, 1, 1};    run(32'h9000_0004, 1); // back to back (R2)
    ackq = '{1, 1, 1, 1};    run(32'h9000_0008, 1);
    ackq = '{3, 3, 1, 1, 1, 3}; run(32'hA000_000C, 1); // double rerun, late both (R10, R11)
    repeat (3) @(negedge clk);
    summary();
  end
endmodule